// File: doc/BRIEF.md
# Clause 45 MDIO Management Slave

This block is the serial management slave of a PHY sub-block. It samples the bidirectional management data line on each rising edge of the externally supplied management clock. It recognises extended-addressing frames and turns them into accesses on a local bank of 16-bit registers. The local bank is reached through a simple synchronous port. That port carries the current register pointer, a write strobe with write data, and read data that the bank returns combinationally for the pointer.

Access is indirect. An address frame loads an internal pointer, and later write, read and read-with-increment frames act on the register that pointer selects. A read-with-increment frame advances the pointer by one once the frame is over. The slave drives the data line only during the turnaround and data phases of a read aimed at it, through an output enable. Frames with the legacy start code, with another port address or device type, or without a full preamble are dropped without any effect.

Top module: `mdio_slave`

## Requirements
- R1: A frame is decoded only when at least 32 consecutive 1 bits precede its first start bit. A 0 bit arriving after fewer than 32 ones restarts the count, and the frame that follows is ignored.
- R2: Start code 01 (legacy format) is ignored. The slave issues no write and no pointer change, and it never asserts `mdio_oe_o`. Only start code 00 opens a frame.
- R3: Opcodes are 00 = address, 01 = write, 11 = read and 10 = read-then-increment. An address frame loads its 16-bit field (MSB first) into the pointer on `reg_addr_o`, one clock after the 16th field bit is sampled.
- R4: A write frame raises `reg_wr_o` for exactly one clock, one clock after the 16th data bit is sampled. During that clock `reg_wdata_o` holds the received word (MSB first) and `reg_addr_o` holds the pointer.
- R5: In a read frame the slave keeps `mdio_oe_o` low for the first turnaround bit and drives 0 for the second. It then drives the 16 bits of the addressed register, MSB first, and releases the line at the next falling edge.
- R6: A read-then-increment frame returns the register at the pointer and then advances the pointer by one, wrapping modulo 2^16. A plain read leaves the pointer unchanged.
- R7: The 5-bit port address and 5-bit device type follow the opcode, each sent MSB first. A frame acts only when both equal `port_addr_i` and `dev_type_i`.
- R8: A device type of 0 never matches, even when `dev_type_i` is 0.
- R9: The values received on `mdio_i` during the two turnaround bits have no effect on the access.
- R10: `mdio_i` is sampled on the rising edge of `mdc_i`. `mdio_o` and `mdio_oe_o` change only on the falling edge.
- R11: When the port address or device type does not match, the slave ignores everything until a new run of 32 ones has been seen. It does not re-decode the bits that follow the mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc_i | input | 1 | Management clock, up to 2.5 MHz |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Received management data line |
| mdio_o | output | 1 | Data driven onto the management line |
| mdio_oe_o | output | 1 | Output enable for `mdio_o` |
| port_addr_i | input | 5 | Configured port address |
| dev_type_i | input | 5 | Configured device type |
| reg_addr_o | output | 16 | Register pointer presented to the bank |
| reg_wr_o | output | 1 | One-clock write strobe |
| reg_wdata_o | output | 16 | Write data |
| reg_rdata_i | input | 16 | Read data for `reg_addr_o` |

## Verification
The bench targets a preamble one bit short of 32 and frames with the legacy start code. A slave that miscounts or ignores the start code would write the bank or drive the line on a frame it should drop. It sends a frame's bits straight after a port mismatch, with no fresh preamble, which catches a slave that resynchronises on a stray 0. It also checks that device type 0 stays unmatched when the configuration is 0. It checks the exact turnaround drive pattern and confirms the pointer moves only after a read-then-increment frame. It toggles `mdio_i` between a rising and the next falling edge and watches the outputs across the high phase. A slave that samples or drives on the wrong edge would corrupt the data or change the line mid-bit.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  typedef enum logic [1:0] {
    OP_ADDR   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_RD_INC = 2'b10,
    OP_READ   = 2'b11
  } mdio_op_e;

  typedef enum logic [2:0] {
    S_HUNT,
    S_ST2,
    S_OP,
    S_PRT,
    S_DEV,
    S_TA,
    S_DATA
  } mdio_state_e;
endpackage

// File: rtl/mdio_preamble.sv
`timescale 1ns/1ps
module mdio_preamble #(
  parameter int PRE_LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic bit_i,
  output logic full_o
);
  localparam int PRE_W = $clog2(PRE_LEN + 1);

  logic [PRE_W-1:0] ones_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= '0;
    end else if (!en_i || !bit_i) begin
      ones_q <= '0;
    end else if (ones_q != PRE_W'(PRE_LEN)) begin
      ones_q <= ones_q + PRE_W'(1);
    end
  end

  assign full_o = (ones_q == PRE_W'(PRE_LEN));

  p_full_holds_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && en_i && bit_i) |=> full_o);

  p_zero_clears_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_i) |=> !full_o);
endmodule

// File: rtl/mdio_frame.sv
`timescale 1ns/1ps
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRT_W = 5,
  parameter int DEV_W = 5,
  parameter int REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_i,
  input  logic             pre_full_i,
  input  logic [PRT_W-1:0] port_addr_i,
  input  logic [DEV_W-1:0] dev_type_i,
  input  logic [REG_W-1:0] rdata_i,
  output logic             hunt_o,
  output logic [REG_W-1:0] ptr_o,
  output logic             wr_o,
  output logic [REG_W-1:0] wdata_o,
  output logic             drv_ta_o,
  output logic             drv_data_o,
  output logic             data_bit_o
);
  localparam int CNT_W = $clog2(REG_W);

  mdio_state_e      state_q;
  mdio_op_e         op_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-2:0] sh_q;
  logic [REG_W-1:0] nxt_sh;
  logic [REG_W-1:0] ptr_q;
  logic [REG_W-1:0] rd_q;
  logic [REG_W-1:0] wdata_q;
  logic             wr_q;
  logic             prt_hit;
  logic             dev_hit;

  assign nxt_sh  = {sh_q, bit_i};
  assign prt_hit = (nxt_sh[PRT_W-1:0] == port_addr_i);
  // reserved device type 0 never matches
  assign dev_hit = (nxt_sh[DEV_W-1:0] == dev_type_i) && (|nxt_sh[DEV_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HUNT;
      op_q    <= OP_ADDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rd_q    <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      sh_q <= nxt_sh[REG_W-2:0];
      case (state_q)
        S_HUNT: begin
          cnt_q <= '0;
          if (pre_full_i && !bit_i) state_q <= S_ST2;
        end
        S_ST2: begin
          cnt_q   <= '0;
          state_q <= bit_i ? S_HUNT : S_OP;
        end
        S_OP: begin
          if (cnt_q == CNT_W'(1)) begin
            op_q    <= mdio_op_e'(nxt_sh[1:0]);
            cnt_q   <= '0;
            state_q <= S_PRT;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        S_PRT: begin
          if (cnt_q == CNT_W'(PRT_W - 1)) begin
            cnt_q   <= '0;
            state_q <= prt_hit ? S_DEV : S_HUNT;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        S_DEV: begin
          if (cnt_q == CNT_W'(DEV_W - 1)) begin
            cnt_q   <= '0;
            state_q <= dev_hit ? S_TA : S_HUNT;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        S_TA: begin
          if (cnt_q == CNT_W'(1)) begin
            cnt_q   <= '0;
            rd_q    <= rdata_i;
            state_q <= S_DATA;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        S_DATA: begin
          rd_q <= {rd_q[REG_W-2:0], 1'b0};
          if (cnt_q == CNT_W'(REG_W - 1)) begin
            cnt_q   <= '0;
            state_q <= S_HUNT;
            case (op_q)
              OP_ADDR:   ptr_q <= nxt_sh;
              OP_WRITE: begin
                wr_q    <= 1'b1;
                wdata_q <= nxt_sh;
              end
              OP_RD_INC: ptr_q <= ptr_q + REG_W'(1);
              default:   ;
            endcase
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          cnt_q   <= '0;
          state_q <= S_HUNT;
        end
      endcase
    end
  end

  assign hunt_o     = (state_q == S_HUNT);
  assign ptr_o      = ptr_q;
  assign wr_o       = wr_q;
  assign wdata_o    = wdata_q;
  assign drv_ta_o   = (state_q == S_TA) && (cnt_q == CNT_W'(1)) && op_q[1];
  assign drv_data_o = (state_q == S_DATA) && op_q[1];
  assign data_bit_o = rd_q[REG_W-1];

  p_start_needs_preamble_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ST2) |-> $past(pre_full_i));

  p_wr_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |=> !wr_q);

  p_ptr_update_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ptr_q) |-> $past(state_q == S_DATA));

  p_wr_ends_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_q |-> (state_q == S_HUNT));
endmodule

// File: rtl/mdio_drive.sv
`timescale 1ns/1ps
module mdio_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drv_ta_i,
  input  logic drv_data_i,
  input  logic data_bit_i,
  output logic mdio_o,
  output logic mdio_oe_o
);
  // output bits launch on the falling edge, half a clock before sampling
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdio_o    <= 1'b0;
      mdio_oe_o <= 1'b0;
    end else begin
      mdio_oe_o <= drv_ta_i | drv_data_i;
      mdio_o    <= drv_data_i & data_bit_i;
    end
  end

  p_ta_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> !mdio_o);

  p_oe_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> (drv_ta_i || drv_data_i));
endmodule

// File: rtl/mdio_slave.sv
`timescale 1ns/1ps
module mdio_slave #(
  parameter int PRT_W   = 5,
  parameter int DEV_W   = 5,
  parameter int REG_W   = 16,
  parameter int PRE_LEN = 32
) (
  input  logic             mdc_i,
  input  logic             rst_ni,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic [PRT_W-1:0] port_addr_i,
  input  logic [DEV_W-1:0] dev_type_i,
  output logic [REG_W-1:0] reg_addr_o,
  output logic             reg_wr_o,
  output logic [REG_W-1:0] reg_wdata_o,
  input  logic [REG_W-1:0] reg_rdata_i
);
  logic hunt;
  logic pre_full;
  logic drv_ta;
  logic drv_data;
  logic data_bit;

  mdio_preamble #(.PRE_LEN(PRE_LEN)) i_preamble (
    .clk_i  (mdc_i),
    .rst_ni (rst_ni),
    .en_i   (hunt),
    .bit_i  (mdio_i),
    .full_o (pre_full)
  );

  mdio_frame #(.PRT_W(PRT_W), .DEV_W(DEV_W), .REG_W(REG_W)) i_frame (
    .clk_i       (mdc_i),
    .rst_ni      (rst_ni),
    .bit_i       (mdio_i),
    .pre_full_i  (pre_full),
    .port_addr_i (port_addr_i),
    .dev_type_i  (dev_type_i),
    .rdata_i     (reg_rdata_i),
    .hunt_o      (hunt),
    .ptr_o       (reg_addr_o),
    .wr_o        (reg_wr_o),
    .wdata_o     (reg_wdata_o),
    .drv_ta_o    (drv_ta),
    .drv_data_o  (drv_data),
    .data_bit_o  (data_bit)
  );

  mdio_drive i_drive (
    .clk_i      (mdc_i),
    .rst_ni     (rst_ni),
    .drv_ta_i   (drv_ta),
    .drv_data_i (drv_data),
    .data_bit_i (data_bit),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o)
  );

  p_no_drive_while_hunting_r11: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    (hunt && $past(hunt)) |-> !mdio_oe_o);
endmodule

// File: tb/test_mdio_slave.sv
`timescale 1ns/1ps
module test_mdio_slave;
  localparam int CLK_PERIOD = 400;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int QTR  = CLK_PERIOD / 4;

  logic        mdc = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdio_in = 1'b1;
  logic        mdio_o, mdio_oe;
  logic [4:0]  prt_cfg = 5'd0;
  logic [4:0]  dev_cfg = 5'd1;
  logic [15:0] reg_addr, reg_wdata, reg_rdata;
  logic        reg_wr;

  logic [15:0] bank [16];
  logic [15:0] model_mem [16];
  logic [15:0] model_ptr = 16'h0;
  int checks = 0, fails = 0, wr_cnt = 0, oe_cnt = 0, exp_wr = 0;

  mdio_slave i_mdio_slave (
    .mdc_i(mdc), .rst_ni(rst_n), .mdio_i(mdio_in), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe),
    .port_addr_i(prt_cfg), .dev_type_i(dev_cfg), .reg_addr_o(reg_addr), .reg_wr_o(reg_wr),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  always #(HALF) mdc = ~mdc;

  always @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) bank[i] <= 16'h0;
    end else begin
      if (reg_wr) begin
        bank[reg_addr[3:0]] <= reg_wdata;
        wr_cnt++;
      end
      if (mdio_oe) oe_cnt++;
    end
  end

  assign reg_rdata = bank[reg_addr[3:0]];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read();
    return model_mem[model_ptr[3:0]];
  endfunction

  function automatic logic [15:0] exp_ptr(input logic [1:0] op, input logic [15:0] data);
    case (op)
      2'b00:   return data;
      2'b10:   return model_ptr + 16'd1;
      default: return model_ptr;
    endcase
  endfunction

  task automatic send_bit(input logic b);
    @(negedge mdc);
    mdio_in = b;
  endtask

  task automatic send_field(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic do_frame(input logic [1:0] st, input logic [1:0] op, input logic [4:0] prt,
                          input logic [4:0] dev, input logic [15:0] data, input int pre_len,
                          input bit valid, input bit glitch);
    logic [15:0] got;
    logic [15:0] exp_rd;
    logic        s_o, s_oe;
    bit          ta_ok;
    bit          rd;
    int          r10_bad;
    got = '0;
    ta_ok = 1'b1;
    r10_bad = 0;
    rd = valid && op[1];
    exp_rd = exp_read();
    repeat (pre_len) send_bit(1'b1);
    send_field({14'h0, st}, 2);
    send_field({14'h0, op}, 2);
    send_field({11'h0, prt}, 5);
    send_field({11'h0, dev}, 5);
    for (int i = 0; i < 18; i++) begin
      logic b;
      if (op[1]) b = 1'b1;
      else if (i < 2) b = 1'($urandom_range(0, 1));   // R9: random turnaround
      else b = data[17-i];
      @(negedge mdc);
      mdio_in = b;
      @(posedge mdc);
      #(QTR);
      if (rd) begin
        if (i == 0 && mdio_oe !== 1'b0) ta_ok = 1'b0;
        if (i == 1 && !(mdio_oe === 1'b1 && mdio_o === 1'b0)) ta_ok = 1'b0;
        if (i >= 2) begin
          got[17-i] = mdio_o;
          if (mdio_oe !== 1'b1) ta_ok = 1'b0;
        end
      end
      s_o = mdio_o;
      s_oe = mdio_oe;
      if (glitch) mdio_in = ~mdio_in;
      #(HALF - QTR - 10);
      if (mdio_o !== s_o || mdio_oe !== s_oe) r10_bad++;
    end
    if (valid) begin
      case (op)
        2'b00: begin
          model_ptr = exp_ptr(op, data);
          chk(reg_addr === model_ptr, "R3", "address frame pointer", {16'h0, reg_addr}, {16'h0, model_ptr});
        end
        2'b01: begin
          chk(reg_wr === 1'b1 && reg_wdata === data && reg_addr === model_ptr, "R4",
              "write strobe/data", {reg_wr, 15'h0, reg_wdata}, {1'b1, 15'h0, data});
          model_mem[model_ptr[3:0]] = data;
          exp_wr++;
          @(posedge mdc);
          #(QTR);
          chk(reg_wr === 1'b0, "R4", "write strobe one clock", {31'h0, reg_wr}, 32'h0);
        end
        default: begin
          chk(ta_ok, "R5", "turnaround/drive enable pattern", {31'h0, ta_ok}, 32'h1);
          chk(got === exp_rd, "R5", "read data", {16'h0, got}, {16'h0, exp_rd});
          model_ptr = exp_ptr(op, data);
          chk(reg_addr === model_ptr, "R6", "pointer after read", {16'h0, reg_addr}, {16'h0, model_ptr});
          @(negedge mdc);
          #(QTR);
          chk(mdio_oe === 1'b0, "R5", "release after data", {31'h0, mdio_oe}, 32'h0);
        end
      endcase
    end
    if (glitch || rd)
      chk(r10_bad == 0, "R10", "outputs changed inside high phase / sampled late", r10_bad, 0);
  endtask

  bit done = 1'b0;

  initial begin
    int w0, o0;
    logic [15:0] p0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) model_mem[i] = 16'h0;
    prt_cfg = 5'h15;
    dev_cfg = 5'h05;
    repeat (3) @(posedge mdc);
    #(QTR);
    chk(mdio_oe === 1'b0 && reg_wr === 1'b0 && reg_addr === 16'h0, "R3", "reset state",
        {mdio_oe, reg_wr, 14'h0, reg_addr}, 32'h0);
    @(negedge mdc);
    rst_n = 1'b1;

    // directed: address, write, read, read-increment, read
    do_frame(2'b00, 2'b00, prt_cfg, dev_cfg, 16'h0003, 32, 1, 1);
    do_frame(2'b00, 2'b01, prt_cfg, dev_cfg, 16'hA5C3, 32, 1, 0);
    do_frame(2'b00, 2'b11, prt_cfg, dev_cfg, 16'h0, 32, 1, 0);
    do_frame(2'b00, 2'b10, prt_cfg, dev_cfg, 16'h0, 40, 1, 0);
    do_frame(2'b00, 2'b11, prt_cfg, dev_cfg, 16'h0, 32, 1, 0);
    // R6: pointer wraps at the top of the space
    do_frame(2'b00, 2'b00, prt_cfg, dev_cfg, 16'hFFFF, 32, 1, 0);
    do_frame(2'b00, 2'b10, prt_cfg, dev_cfg, 16'h0, 32, 1, 0);

    // R1: only 31 ones before the start bit
    w0 = wr_cnt; p0 = reg_addr;
    send_bit(1'b0);
    do_frame(2'b00, 2'b00, prt_cfg, dev_cfg, 16'h0009, 31, 0, 0);
    do_frame(2'b00, 2'b01, prt_cfg, dev_cfg, 16'h1234, 0, 0, 0);
    chk(wr_cnt == w0 && reg_addr === p0, "R1", "short preamble ignored", {wr_cnt[15:0], reg_addr}, {w0[15:0], p0});

    // R2: legacy start code, write and read
    w0 = wr_cnt; o0 = oe_cnt; p0 = reg_addr;
    do_frame(2'b01, 2'b01, prt_cfg, dev_cfg, 16'hBEEF, 32, 0, 0);
    do_frame(2'b01, 2'b11, prt_cfg, dev_cfg, 16'h0, 32, 0, 0);
    do_frame(2'b01, 2'b00, prt_cfg, dev_cfg, 16'h0007, 32, 0, 0);
    chk(wr_cnt == w0 && oe_cnt == o0 && reg_addr === p0, "R2", "legacy frames ignored",
        {wr_cnt[7:0], oe_cnt[7:0], reg_addr}, {w0[7:0], o0[7:0], p0});

    // R7 + R11: port mismatch, then a frame with no fresh preamble
    w0 = wr_cnt; o0 = oe_cnt;
    do_frame(2'b00, 2'b01, prt_cfg ^ 5'h10, dev_cfg, 16'h0000, 32, 0, 0);
    do_frame(2'b00, 2'b01, prt_cfg, dev_cfg, 16'h5555, 0, 0, 0);
    chk(wr_cnt == w0, "R11", "no decode without new preamble", wr_cnt, w0);
    do_frame(2'b00, 2'b11, prt_cfg, dev_cfg ^ 5'h01, 16'h0, 32, 0, 0);
    chk(oe_cnt == o0, "R7", "device mismatch read not driven", oe_cnt, o0);
    do_frame(2'b00, 2'b01, prt_cfg, dev_cfg, 16'h6A6A, 32, 1, 0);

    // R8: configured device type 0 still never matches
    dev_cfg = 5'h00;
    w0 = wr_cnt; o0 = oe_cnt;
    do_frame(2'b00, 2'b01, prt_cfg, 5'h00, 16'hCAFE, 32, 0, 0);
    do_frame(2'b00, 2'b11, prt_cfg, 5'h00, 16'h0, 32, 0, 0);
    chk(wr_cnt == w0 && oe_cnt == o0, "R8", "device type 0 rejected",
        {wr_cnt[15:0], oe_cnt[15:0]}, {w0[15:0], o0[15:0]});
    dev_cfg = 5'h05;

    // random traffic with new configuration
    prt_cfg = 5'($urandom_range(0, 31));
    dev_cfg = 5'($urandom_range(1, 31));
    for (int n = 0; n < 48; n++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      do_frame(2'b00, op, prt_cfg, dev_cfg, 16'($urandom), 32 + $urandom_range(0, 4), 1, (n % 8) == 0);
    end
    chk(wr_cnt == exp_wr, "R4", "total write strobes", wr_cnt, exp_wr);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge mdc);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule